// File: doc/BRIEF.md
# Byte-Port DMA Channel Register Bank

This block is the programming face of a four-channel DMA engine whose control bus is only eight bits wide. Each channel holds a 16-bit start address, a 16-bit transfer count, a six-bit mode field, a mask bit and an 8-bit page byte. The address and count are loaded one byte at a time through a single port each. One toggle bit, shared by every channel, decides whether a byte access reaches the low half or the high half of a 16-bit register. The count is held as the number of transfers minus one.

Every write to an address or count register loads both the base copy and the working copy. The working copies advance on a per-channel step input, which the transfer engine pulses once per completed transfer. Software reads the working address and count back through the same byte ports.

Top module: `dmareg_top`

## Requirements
- R1: After a synchronous reset the pointer bit is clear, all four mask bits are set, every mode field is zero, and every address, count and page register reads zero.
- R2: A read or write on ports 0x0 to 0x7 toggles the pointer bit. While the bit is clear the access reaches bits [7:0], and while it is set the access reaches bits [15:8].
- R3: A write to port 0xC clears the pointer bit whatever the data byte holds.
- R4: Port 2*ch is the address register of channel ch. A write there updates that byte in both the base and the working address, and a read returns the working address byte.
- R5: Port 2*ch+1 is the count register, which holds the transfer count minus one. A write updates base and working count alike, and a read returns the working count byte.
- R6: A step pulse on an unmasked channel decrements its working count by one, wrapping from 0x0000 to 0xFFFF, and increments its working address by one. A step pulse on a masked channel changes nothing.
- R7: Suppose one cycle carries both a register write and a step for the same channel. The register that is written takes the newly programmed base value, and the step does not change it.
- R8: A write to port 0xA names the channel in data bits [1:0]. Data bit 2 set masks that channel, and bit 2 clear unmasks it.
- R9: A write to port 0xB names the channel in data bits [1:0] and stores data bits [7:2] as that channel's mode field (bits [7:6] kind, where 11 is cascade; bits [3:2] direction).
- R10: A write to port 0xE or port 0xF has a fixed effect on all four mask bits. Port 0xF loads them from data bits [3:0]. Port 0xE clears all four at once.
- R11: A write to port 0xD clears the pointer bit, sets all mask bits and zeroes every mode field. It leaves address, count and page registers unchanged.
- R12: A pulse on the page-write input loads the data byte into the page register of the channel named by the page-select input.
- R13: A read of any port from 0x8 to 0xF returns zero and leaves the pointer bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe for the register port |
| rd_en | input | 1 | Byte read strobe; ignored while wr_en is high |
| port_addr | input | 4 | Register port offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from port_addr and the pointer |
| pg_wr | input | 1 | Page register write strobe |
| pg_sel | input | 2 | Channel whose page register pg_wr loads |
| step_i | input | 4 | One bit per channel: a transfer has completed |
| mask_o | output | 4 | Per-channel mask bits |
| mode_o | output | 24 | Six-bit mode field per channel, channel 0 in the low bits |
| page_o | output | 32 | Page byte per channel, channel 0 in the low bits |
| ptr_hi_o | output | 1 | Pointer bit: 1 means the next access reaches the high byte |

## Verification
A byte write to a channel's count or address register can land in the same cycle as that channel's step pulse. The two then compete for the same working register. The bench unmasks a channel, then writes the count low byte in the very cycle that pulses its step input. It reads the count back through the port and expects the freshly programmed value, with no decrement applied. A companion step on a masked channel checks that such a collision never arises from a masked request.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int NCH   = 4;
    localparam int BW    = 8;
    localparam int RW    = 2 * BW;
    localparam int CHW   = $clog2(NCH);
    localparam int PW    = 4;
    localparam int MODEW = 6;

    localparam logic [PW-1:0] P_STATUS  = 4'h8;
    localparam logic [PW-1:0] P_MASK1   = 4'hA;
    localparam logic [PW-1:0] P_MODE    = 4'hB;
    localparam logic [PW-1:0] P_CLRPTR  = 4'hC;
    localparam logic [PW-1:0] P_MCLR    = 4'hD;
    localparam logic [PW-1:0] P_UNMASKA = 4'hE;
    localparam logic [PW-1:0] P_MASKALL = 4'hF;

    typedef struct packed {
        logic [1:0] kind;   // data [7:6], 11 = cascade
        logic       dn;     // data [5]
        logic       auto;   // data [4]
        logic [1:0] dir;    // data [3:2], 01 io->mem, 10 mem->io
    } mode_t;

    typedef struct packed {
        logic            hit;
        logic [CHW-1:0]  ch;
        logic            is_cnt;
    } chsel_t;

    function automatic chsel_t decode_chan(input logic [PW-1:0] a);
        chsel_t s;
        s.hit    = (a[PW-1] == 1'b0);
        s.ch     = a[CHW:1];
        s.is_cnt = a[0];
        return s;
    endfunction

    function automatic logic [RW-1:0] merge_byte(input logic [RW-1:0] w,
                                                 input logic [BW-1:0] b,
                                                 input logic          hi);
        return hi ? {b, w[BW-1:0]} : {w[RW-1:BW], b};
    endfunction

    function automatic logic [BW-1:0] pick_byte(input logic [RW-1:0] w,
                                                input logic          hi);
        return hi ? w[RW-1:BW] : w[BW-1:0];
    endfunction

endpackage

// File: rtl/dmareg_ptr.sv
module dmareg_ptr (
    input  logic clk,
    input  logic rst,
    input  logic access,
    input  logic clr,
    output logic ptr_hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) ptr_hi <= 1'b0;
        else if (access) ptr_hi <= ~ptr_hi;
    end

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ptr_hi);

    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (access && !clr) |=> (ptr_hi != $past(ptr_hi)));

    assert_ptr_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (!access && !clr) |=> $stable(ptr_hi));
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
    import dmareg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_mask1,
    input  logic                 wr_mode,
    input  logic                 wr_maskall,
    input  logic                 wr_unmaskall,
    input  logic                 mclr,
    input  logic [BW-1:0]        wdata,
    output logic [NCH-1:0]       mask,
    output mode_t [NCH-1:0]      mode
);
    logic [CHW-1:0] sel;
    assign sel = wdata[CHW-1:0];

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mask <= '1;
            mode <= '0;
        end else begin
            if (wr_mask1)     mask[sel] <= wdata[2];
            if (wr_maskall)   mask      <= wdata[NCH-1:0];
            if (wr_unmaskall) mask      <= '0;
            if (wr_mode)      mode[sel] <= mode_t'(wdata[BW-1:2]);
        end
    end

    assert_mclr_state_R11: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mask == '1 && mode == '0));

    assert_maskall_load_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_maskall && !mclr) |=> (mask == $past(wdata[NCH-1:0])));

    assert_unmaskall_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_unmaskall && !mclr) |=> (mask == '0));

    assert_mask1_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_mask1 && !mclr) |=> (mask[$past(sel)] == $past(wdata[2])));
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_a,
    input  logic          wr_c,
    input  logic          hi,
    input  logic [BW-1:0] wdata,
    input  logic          step,
    input  logic          pg_wr,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] cur_cnt,
    output logic [BW-1:0] page
);
    logic [RW-1:0] base_addr, base_cnt;
    logic [RW-1:0] nxt_addr, nxt_cnt;

    assign nxt_addr = merge_byte(base_addr, wdata, hi);
    assign nxt_cnt  = merge_byte(base_cnt,  wdata, hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            page      <= '0;
        end else begin
            if (pg_wr) page <= wdata;
            if (wr_a) begin
                base_addr <= nxt_addr;
                cur_addr  <= nxt_addr;
            end else if (step) begin
                cur_addr  <= cur_addr + 1'b1;
            end
            if (wr_c) begin
                base_cnt <= nxt_cnt;
                cur_cnt  <= nxt_cnt;
            end else if (step) begin
                cur_cnt  <= cur_cnt - 1'b1;
            end
        end
    end

    assert_step_dec_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_c) |=> (cur_cnt == $past(cur_cnt) - 16'd1));

    assert_step_inc_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_a) |=> (cur_addr == $past(cur_addr) + 16'd1));

    assert_wr_wins_R7: assert property (@(posedge clk) disable iff (rst)
        wr_c |=> (cur_cnt == base_cnt));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_c) |=> $stable(cur_cnt));
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [3:0]           port_addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic                 pg_wr,
    input  logic [1:0]           pg_sel,
    input  logic [3:0]           step_i,
    output logic [3:0]           mask_o,
    output logic [23:0]          mode_o,
    output logic [31:0]          page_o,
    output logic                 ptr_hi_o
);
    chsel_t         dsel;
    logic           acc, wr_any, rd_only;
    logic           clr_ptr, mclr;
    logic [NCH-1:0] mask;
    mode_t [NCH-1:0] mode;
    logic [RW-1:0]  cur_addr [NCH];
    logic [RW-1:0]  cur_cnt  [NCH];

    assign dsel    = decode_chan(port_addr);
    assign wr_any  = wr_en;
    assign rd_only = rd_en && !wr_en;
    assign acc     = dsel.hit && (wr_any || rd_only);
    assign mclr    = wr_en && (port_addr == P_MCLR);
    assign clr_ptr = (wr_en && (port_addr == P_CLRPTR)) || mclr;

    dmareg_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .access (acc),
        .clr    (clr_ptr),
        .ptr_hi (ptr_hi_o)
    );

    dmareg_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_mask1     (wr_en && (port_addr == P_MASK1)),
        .wr_mode      (wr_en && (port_addr == P_MODE)),
        .wr_maskall   (wr_en && (port_addr == P_MASKALL)),
        .wr_unmaskall (wr_en && (port_addr == P_UNMASKA)),
        .mclr         (mclr),
        .wdata        (wdata),
        .mask         (mask),
        .mode         (mode)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic wa, wc;
        assign wa = wr_en && dsel.hit && (dsel.ch == g) && !dsel.is_cnt;
        assign wc = wr_en && dsel.hit && (dsel.ch == g) &&  dsel.is_cnt;

        dmareg_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_a     (wa),
            .wr_c     (wc),
            .hi       (ptr_hi_o),
            .wdata    (wdata),
            .step     (step_i[g] && !mask[g]),
            .pg_wr    (pg_wr && (pg_sel == g)),
            .cur_addr (cur_addr[g]),
            .cur_cnt  (cur_cnt[g]),
            .page     (page_o[g*BW +: BW])
        );

        assign mode_o[g*MODEW +: MODEW] = mode[g];
    end

    always_comb begin
        rdata = '0;
        if (dsel.hit) begin
            rdata = dsel.is_cnt ? pick_byte(cur_cnt[dsel.ch], ptr_hi_o)
                                : pick_byte(cur_addr[dsel.ch], ptr_hi_o);
        end
    end

    assign mask_o = mask;

    assert_high_read_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (port_addr >= P_STATUS) |-> (rdata == 8'h00));

    assert_masked_step_R6: assert property (@(posedge clk) disable iff (rst)
        (step_i[0] && mask_o[0] && !(wr_en && port_addr == 4'h1)) |=>
            $stable(g_chan[0].u_chan.cur_cnt));
endmodule

// File: tb/dmareg_top_tb.sv
module dmareg_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, pg_wr;
    logic [3:0]  port_addr;
    logic [7:0]  wdata, rdata;
    logic [1:0]  pg_sel;
    logic [3:0]  step_i, mask_o;
    logic [23:0] mode_o;
    logic [31:0] page_o;
    logic        ptr_hi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dmareg_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .port_addr(port_addr), .wdata(wdata), .rdata(rdata),
        .pg_wr(pg_wr), .pg_sel(pg_sel), .step_i(step_i),
        .mask_o(mask_o), .mode_o(mode_o), .page_o(page_o), .ptr_hi_o(ptr_hi_o)
    );

    localparam logic [1:0] OPW = 2'd0;
    localparam logic [1:0] OPR = 2'd1;
    localparam int NV = 18;
    // {op, port, write data, expected read data}
    localparam logic [21:0] VEC [NV] = '{
        {OPW, 4'hC, 8'h00, 8'h00},
        {OPW, 4'h2, 8'h34, 8'h00},
        {OPW, 4'h2, 8'h12, 8'h00},
        {OPW, 4'h3, 8'hFF, 8'h00},
        {OPW, 4'h3, 8'h00, 8'h00},
        {OPR, 4'h2, 8'h00, 8'h34},
        {OPR, 4'h2, 8'h00, 8'h12},
        {OPR, 4'h3, 8'h00, 8'hFF},
        {OPR, 4'h3, 8'h00, 8'h00},
        {OPW, 4'h6, 8'hAA, 8'h00},
        {OPW, 4'hC, 8'h55, 8'h00},
        {OPW, 4'h6, 8'hBB, 8'h00},
        {OPW, 4'h6, 8'hCC, 8'h00},
        {OPR, 4'h6, 8'h00, 8'hBB},
        {OPR, 4'h6, 8'h00, 8'hCC},
        {OPR, 4'h9, 8'h00, 8'h00},
        {OPR, 4'h6, 8'h00, 8'hBB},
        {OPR, 4'h6, 8'h00, 8'hCC}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; port_addr = a;
        #1;
        chk(rdata == exp, req, {24'd0, rdata}, {24'd0, exp});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic step(input logic [3:0] s);
        @(negedge clk);
        step_i = s;
        @(negedge clk);
        step_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; pg_wr = 0; pg_sel = 0;
        port_addr = 0; wdata = 0; step_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk(mask_o == 4'hF, "R1 mask", {28'd0, mask_o}, 32'hF);
        chk(mode_o == 24'd0, "R1 mode", {8'd0, mode_o}, 32'd0);
        chk(ptr_hi_o == 1'b0, "R1 ptr", {31'd0, ptr_hi_o}, 32'd0);
        chk(page_o == 32'd0, "R1 page", page_o, 32'd0);
        rd_chk(4'h5, 8'h00, "R1 count lo");
        rd_chk(4'h5, 8'h00, "R1 count hi");

        // Vector table: R2 R3 R4 R5 R13
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21:20] == OPW) wr(VEC[i][19:16], VEC[i][15:8]);
            else rd_chk(VEC[i][19:16], VEC[i][7:0], "R2/R4/R5/R13 vector");
        end
        chk(ptr_hi_o == 1'b0, "R2 ptr after pairs", {31'd0, ptr_hi_o}, 32'd0);

        // R8 unmask channel 1 (data bits [1:0]=ch, bit2=set)
        wr(4'hA, 8'h01);
        chk(mask_o == 4'hD, "R8 unmask", {28'd0, mask_o}, 32'hD);

        // R6 step unmasked ch1, masked ch3
        step(4'b1010);
        rd_chk(4'h3, 8'hFE, "R6 count dec lo");
        rd_chk(4'h3, 8'h00, "R6 count dec hi");
        rd_chk(4'h2, 8'h35, "R6 addr inc lo");
        rd_chk(4'h2, 8'h12, "R6 addr inc hi");
        rd_chk(4'h7, 8'h00, "R6 masked ch3 lo");
        rd_chk(4'h7, 8'h00, "R6 masked ch3 hi");
        wr(4'hA, 8'h03);
        step(4'b1000);
        rd_chk(4'h7, 8'hFF, "R6 wrap lo");
        rd_chk(4'h7, 8'hFF, "R6 wrap hi");

        // R7 write and step on ch1 in the same cycle
        @(negedge clk);
        wr_en = 1'b1; port_addr = 4'h3; wdata = 8'h10; step_i = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; step_i = 4'b0000;
        wr(4'hC, 8'h00);
        rd_chk(4'h3, 8'h10, "R7 write wins lo");
        rd_chk(4'h3, 8'h00, "R7 write wins hi");

        // R9 mode
        wr(4'hB, 8'h45);
        chk(mode_o[11:6] == 6'h11, "R9 ch1 mode", {26'd0, mode_o[11:6]}, 32'h11);
        wr(4'hB, 8'hC2);
        chk(mode_o[17:12] == 6'h30, "R9 ch2 cascade", {26'd0, mode_o[17:12]}, 32'h30);

        // R8 set mask
        wr(4'hA, 8'h05);
        chk(mask_o[1] == 1'b1, "R8 mask set", {31'd0, mask_o[1]}, 32'd1);

        // R10 mask all / clear all
        wr(4'hF, 8'h0A);
        chk(mask_o == 4'hA, "R10 maskall", {28'd0, mask_o}, 32'hA);
        wr(4'hE, 8'hFF);
        chk(mask_o == 4'h0, "R10 unmaskall", {28'd0, mask_o}, 32'h0);

        // R12 page
        @(negedge clk); pg_wr = 1'b1; pg_sel = 2'd2; wdata = 8'h7E;
        @(negedge clk); pg_wr = 1'b0;
        chk(page_o[23:16] == 8'h7E, "R12 page ch2", {24'd0, page_o[23:16]}, 32'h7E);
        chk(page_o[15:8] == 8'h00, "R12 page ch1 untouched", {24'd0, page_o[15:8]}, 32'h0);

        // R11 master clear with pointer set
        wr(4'h0, 8'h99);
        chk(ptr_hi_o == 1'b1, "R2 ptr set", {31'd0, ptr_hi_o}, 32'd1);
        wr(4'hD, 8'h00);
        chk(ptr_hi_o == 1'b0, "R11 ptr", {31'd0, ptr_hi_o}, 32'd0);
        chk(mask_o == 4'hF, "R11 mask", {28'd0, mask_o}, 32'hF);
        chk(mode_o == 24'd0, "R11 mode", {8'd0, mode_o}, 32'd0);
        chk(page_o[23:16] == 8'h7E, "R11 page kept", {24'd0, page_o[23:16]}, 32'h7E);
        rd_chk(4'h3, 8'h10, "R11 count kept lo");
        rd_chk(4'h3, 8'h00, "R11 count kept hi");

        // R3 clear ignores data, R13 read of 0xF no toggle
        wr(4'h4, 8'h01);
        wr(4'hC, 8'hFF);
        chk(ptr_hi_o == 1'b0, "R3 clear", {31'd0, ptr_hi_o}, 32'd0);
        rd_chk(4'hF, 8'h00, "R13 high port read");
        chk(ptr_hi_o == 1'b0, "R13 no toggle", {31'd0, ptr_hi_o}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule